// File: doc/BRIEF.md
# Four-Output Bridge Steering Logic

This block takes one pulse-width-modulated input and distributes it over four bridge outputs, A to D, under a selectable operating mode. In the full-bridge mode, three outputs sit at fixed levels and one follows the input. A direction control picks which diagonal of the bridge conducts. In push-pull mode, successive input pulses go to A and B in turn. In steering mode, each output either copies the input or holds a programmed level, chosen output by output.

Changes to the steering enables and to the direction bit can be applied at once, or held back until the next rising edge of the input. Holding them back keeps a change from landing in the middle of a pulse. The output levels are registered, so the outputs are free of glitches. Dead-band timing, shutdown and pin multiplexing sit outside this block.

Top module: `bridge_steer`

## Requirements
- R1: While reset is held, and after it is released until an input arrives, all four outputs are low and every steering enable takes effect as cleared.
- R2: Outputs are registered. `out_abcd` (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D) reflects the inputs sampled at the previous rising clock edge, and does not change between edges.
- R3: With `mode` = 2'b10 and the effective direction 0 (forward), A is high, B and C are low, and D equals `pwm_in`.
- R4: With `mode` = 2'b10 and the effective direction 1 (reverse), C is high, A and D are low, and B equals `pwm_in`.
- R5: With `mode` = 2'b01 (push-pull), C and D are low and exactly one of A or B carries `pwm_in`. The carrier swaps at every rising edge of `pwm_in`. The first edge after reset selects A.
- R6: With `mode` = 2'b00 (steering), every output whose effective enable bit is 1 equals `pwm_in`. Any combination of the four may be enabled.
- R7: In steering mode, every output whose effective enable bit is 0 drives its bit of `steer_lvl`. That bit applies with the normal one-cycle latency, with no hold-back.
- R8: With `sync_upd` = 1, new values of `steer_en` and `dir_rev` take effect only in a clock cycle where a rising input edge is sampled. A rising edge means `pwm_in` is 1 now and was 0 at the previous clock edge. In every other cycle the previously taken values stay in force.
- R9: With `sync_upd` = 0, `steer_en` and `dir_rev` take effect in the clock cycle in which they are sampled.
- R10: With `mode` = 2'b11, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| pwm_in | input | 1 | Pulse-width-modulated input, synchronous to clk |
| mode | input | 2 | 00 steering, 01 push-pull, 10 full-bridge, 11 all outputs low |
| dir_rev | input | 1 | Full-bridge direction: 0 forward, 1 reverse |
| sync_upd | input | 1 | 1 holds enable and direction changes until the next rising input edge |
| steer_en | input | 4 | Per-output steering enable (bit 0 = A) |
| steer_lvl | input | 4 | Per-output fixed level used when that enable is 0 |
| out_abcd | output | 4 | Bridge outputs, bit 0 = A to bit 3 = D |

## Verification
The bench builds the block with its default `PP_FIRST` = 0. With that value, the first push-pull pulse after reset goes to output A, and the directed sequence checks this. Random phases change the mode, the direction, the update mode and the steering bits at random times, while the input toggles at irregular rates. This brings into reach enable changes that land in a cycle with a rising edge and in cycles without one, and direction changes in the middle of a pulse. A directed case changes the enables while the input stays high, which has no rising edge, so the bench can observe that the change is held back.

// File: rtl/bridge_steer_pkg.sv
`timescale 1ns/1ps
package bridge_steer_pkg;
    localparam int unsigned N_OUT  = 4;
    localparam int unsigned MODE_W = 2;
    localparam int unsigned IDX_A  = 0;
    localparam int unsigned IDX_B  = 1;
    localparam int unsigned IDX_C  = 2;
    localparam int unsigned IDX_D  = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_STEER    = 2'b00,
        MD_PUSHPULL = 2'b01,
        MD_FULLBR   = 2'b10,
        MD_IDLE     = 2'b11
    } mode_e;
endpackage

// File: rtl/bs_edge.sv
`timescale 1ns/1ps
module bs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_i,
    output logic rise_o
);
    typedef struct packed {
        logic pwm;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwm = pwm_i;
        rise_o   = pwm_i && !st_q.pwm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/bs_ctrl_latch.sv
`timescale 1ns/1ps
module bs_ctrl_latch
    import bridge_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             rise_i,
    input  logic [N_OUT-1:0] en_i,
    input  logic             dir_i,
    output logic [N_OUT-1:0] en_eff_o,
    output logic             dir_eff_o
);
    typedef struct packed {
        logic [N_OUT-1:0] en;
        logic             dir;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        if (!sync_i || rise_i) begin
            en_eff_o  = en_i;
            dir_eff_o = dir_i;
        end else begin
            en_eff_o  = st_q.en;
            dir_eff_o = st_q.dir;
        end
        st_d.en  = en_eff_o;
        st_d.dir = dir_eff_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !rise_i) ##1 (sync_i && !rise_i) |-> ($stable(en_eff_o) && $stable(dir_eff_o)));
endmodule

// File: rtl/bs_pushpull.sv
`timescale 1ns/1ps
module bs_pushpull #(
    parameter bit PP_FIRST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pp_i,
    input  logic rise_i,
    output logic sel_o
);
    localparam bit SEL_RST = ~PP_FIRST;

    typedef struct packed {
        logic sel;
    } pp_st_t;

    pp_st_t st_d, st_q;

    always_comb begin
        sel_o    = (pp_i && rise_i) ? ~st_q.sel : st_q.sel;
        st_d.sel = sel_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.sel <= SEL_RST;
        else        st_q     <= st_d;
    end

    // R5
    pp_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_i && rise_i) |=> (st_q.sel != $past(st_q.sel)));
endmodule

// File: rtl/bs_outmap.sv
`timescale 1ns/1ps
module bs_outmap
    import bridge_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode_i,
    input  logic             dir_i,
    input  logic [N_OUT-1:0] en_i,
    input  logic [N_OUT-1:0] lvl_i,
    input  logic             pwm_i,
    input  logic             sel_i,
    output logic [N_OUT-1:0] out_o
);
    typedef struct packed {
        logic [N_OUT-1:0] out;
    } map_st_t;

    map_st_t          st_d, st_q;
    logic [N_OUT-1:0] steer_v;

    for (genvar i = 0; i < N_OUT; i++) begin : g_steer
        assign steer_v[i] = en_i[i] ? pwm_i : lvl_i[i];
    end

    always_comb begin
        st_d.out = '0;
        unique case (mode_i)
            MD_STEER: st_d.out = steer_v;
            MD_PUSHPULL: begin
                st_d.out[IDX_A] = pwm_i && !sel_i;
                st_d.out[IDX_B] = pwm_i &&  sel_i;
            end
            MD_FULLBR: begin
                if (!dir_i) begin
                    st_d.out[IDX_A] = 1'b1;
                    st_d.out[IDX_D] = pwm_i;
                end else begin
                    st_d.out[IDX_C] = 1'b1;
                    st_d.out[IDX_B] = pwm_i;
                end
            end
            default: st_d.out = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.out;

    // R3
    fwd_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_FULLBR && !dir_i) |=>
        (out_o[IDX_A] && !out_o[IDX_B] && !out_o[IDX_C] && out_o[IDX_D] == $past(pwm_i)));
    // R4
    rev_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_FULLBR && dir_i) |=>
        (!out_o[IDX_A] && out_o[IDX_B] == $past(pwm_i) && out_o[IDX_C] && !out_o[IDX_D]));
    // R5
    pp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_PUSHPULL) |=> ($onehot0(out_o) && !out_o[IDX_C] && !out_o[IDX_D]));
    // R7
    steer_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_STEER) |=> ((out_o & ~$past(en_i)) == ($past(lvl_i) & ~$past(en_i))));
    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_IDLE) |=> (out_o == '0));
endmodule

// File: rtl/bridge_steer.sv
`timescale 1ns/1ps
module bridge_steer
    import bridge_steer_pkg::*;
#(
    parameter bit PP_FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    input  logic [MODE_W-1:0] mode,
    input  logic             dir_rev,
    input  logic             sync_upd,
    input  logic [N_OUT-1:0] steer_en,
    input  logic [N_OUT-1:0] steer_lvl,
    output logic [N_OUT-1:0] out_abcd
);
    logic             rise;
    logic [N_OUT-1:0] en_eff;
    logic             dir_eff;
    logic             sel;
    mode_e            mode_t;

    assign mode_t = mode_e'(mode);

    bs_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_i  (pwm_in),
        .rise_o (rise)
    );

    bs_ctrl_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_upd),
        .rise_i    (rise),
        .en_i      (steer_en),
        .dir_i     (dir_rev),
        .en_eff_o  (en_eff),
        .dir_eff_o (dir_eff)
    );

    bs_pushpull #(.PP_FIRST(PP_FIRST)) u_pp (
        .clk    (clk),
        .rst_n  (rst_n),
        .pp_i   (mode_t == MD_PUSHPULL),
        .rise_i (rise),
        .sel_o  (sel)
    );

    bs_outmap u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_t),
        .dir_i  (dir_eff),
        .en_i   (en_eff),
        .lvl_i  (steer_lvl),
        .pwm_i  (pwm_in),
        .sel_i  (sel),
        .out_o  (out_abcd)
    );

    // R9
    async_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_upd && mode_t == MD_STEER) |=> ((out_abcd & $past(steer_en)) == ({N_OUT{$past(pwm_in)}} & $past(steer_en))));
endmodule

// File: tb/bridge_steer_tb.sv
`timescale 1ns/1ps
module bridge_steer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic [1:0] mode = 2'b11;
    logic       dir_rev = 1'b0;
    logic       sync_upd = 1'b0;
    logic [3:0] steer_en = 4'h0;
    logic [3:0] steer_lvl = 4'h0;
    logic [3:0] out_abcd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic       m_prev, m_dir, m_sel;
    logic [3:0] m_en;

    always #5 clk = ~clk;

    bridge_steer u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .mode(mode),
        .dir_rev(dir_rev), .sync_upd(sync_upd), .steer_en(steer_en),
        .steer_lvl(steer_lvl), .out_abcd(out_abcd)
    );

    function automatic logic [3:0] map_out(input logic [1:0] md, input logic d,
                                           input logic [3:0] en, input logic [3:0] lv,
                                           input logic p, input logic s);
        logic [3:0] r;
        r = 4'h0;
        case (md)
            2'b00: for (int i = 0; i < 4; i++) r[i] = en[i] ? p : lv[i];
            2'b01: begin r[0] = p & ~s; r[1] = p & s; end
            2'b10: r = d ? {1'b0, 1'b1, p, 1'b0} : {p, 1'b0, 1'b0, 1'b1};
            default: r = 4'h0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] md, input logic sy, input logic d);
        case (md)
            2'b00:   return sy ? "R8" : "R6";
            2'b01:   return "R5";
            2'b10:   return d ? "R4" : "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] exp);
        n_chk++;
        if (out_abcd !== exp) begin
            n_bad++;
            $display("FAIL %s: out_abcd=%b expected=%b at %0t", tag, out_abcd, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_prev = 1'b0; m_dir = 1'b0; m_sel = 1'b1; m_en = 4'h0;
    endtask

    // drive at a falling edge, advance one clock, compare at the next falling edge
    task automatic step(input logic [1:0] md, input logic d, input logic sy,
                        input logic [3:0] en, input logic [3:0] lv, input logic p,
                        input string tag);
        logic rise, d_e, s_e;
        logic [3:0] en_e, exp;
        mode = md; dir_rev = d; sync_upd = sy; steer_en = en; steer_lvl = lv; pwm_in = p;
        rise = p & ~m_prev;
        en_e = (!sy || rise) ? en : m_en;
        d_e  = (!sy || rise) ? d  : m_dir;
        s_e  = (md == 2'b01 && rise) ? ~m_sel : m_sel;
        exp  = map_out(md, d_e, en_e, lv, p, s_e);
        m_prev = p; m_en = en_e; m_dir = d_e; m_sel = s_e;
        @(negedge clk);
        chk(tag, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] md;
        logic d, sy, p;
        logic [3:0] en, lv;
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(negedge clk);
        chk("R1", 4'h0);
        mode = 2'b00; steer_lvl = 4'h0; steer_en = 4'hF; pwm_in = 1'b1;
        @(negedge clk);
        chk("R1", 4'h0);
        rst_n = 1'b1;
        pwm_in = 1'b0; mode = 2'b00; steer_en = 4'h0;
        @(negedge clk);
        chk("R1", 4'h0);
        m_prev = 1'b0;

        // push-pull: first pulse to A, then B
        step(2'b01, 0, 0, 4'h0, 4'h0, 0, "R5");
        step(2'b01, 0, 0, 4'h0, 4'h0, 1, "R5"); chk("R5", 4'b0001);
        step(2'b01, 0, 0, 4'h0, 4'h0, 1, "R5"); chk("R5", 4'b0001);
        step(2'b01, 0, 0, 4'h0, 4'h0, 0, "R5"); chk("R5", 4'b0000);
        step(2'b01, 0, 0, 4'h0, 4'h0, 1, "R5"); chk("R5", 4'b0010);

        // full bridge
        step(2'b10, 0, 0, 4'h0, 4'h0, 1, "R3"); chk("R3", 4'b1001);
        step(2'b10, 0, 0, 4'h0, 4'h0, 0, "R3"); chk("R3", 4'b0001);
        mode = 2'b10; dir_rev = 1'b1; pwm_in = 1'b1;
        #1 chk("R2", 4'b0001);
        m_dir = 1'b1;
        step(2'b10, 1, 0, 4'h0, 4'h0, 1, "R4"); chk("R4", 4'b0110);
        step(2'b11, 1, 0, 4'h0, 4'h0, 1, "R10"); chk("R10", 4'b0000);

        // steering: levels, then held enable change, then immediate change
        step(2'b00, 0, 0, 4'h0, 4'b1010, 0, "R7"); chk("R7", 4'b1010);
        step(2'b00, 0, 0, 4'h0, 4'b0101, 1, "R7"); chk("R7", 4'b0101);
        step(2'b00, 0, 1, 4'hF, 4'b0101, 1, "R8"); chk("R8", 4'b0101);
        step(2'b00, 0, 1, 4'hF, 4'b0101, 0, "R8"); chk("R8", 4'b0101);
        step(2'b00, 0, 1, 4'hF, 4'b0101, 1, "R8"); chk("R8", 4'b1111);
        step(2'b00, 0, 0, 4'b0011, 4'b0000, 1, "R9"); chk("R9", 4'b0011);
        step(2'b00, 0, 0, 4'b1100, 4'b0000, 1, "R9"); chk("R9", 4'b1100);
        step(2'b00, 0, 0, 4'b1100, 4'b0000, 0, "R6"); chk("R6", 4'b0000);

        // random phases
        for (int ph = 0; ph < 80; ph++) begin
            md = 2'($urandom_range(0, 3));
            sy = 1'($urandom);
            d  = 1'($urandom);
            en = 4'($urandom);
            lv = 4'($urandom);
            p  = pwm_in;
            for (int c = 0; c < int'($urandom_range(20, 60)); c++) begin
                if ($urandom_range(0, 3) == 0) p = ~p;
                if ($urandom_range(0, 9) == 0) en = 4'($urandom);
                if ($urandom_range(0, 9) == 0) lv = 4'($urandom);
                if ($urandom_range(0, 15) == 0) d = ~d;
                step(md, d, sy, en, lv, p, tag_of(md, sy, d));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule